// File: doc/BRIEF.md
# E1 Receive Frame Aligner

This block locks onto the 256-bit frame of a serial E1 receive stream that arrives one bit per clock. It hunts for the alignment word in time slot 0 and confirms it over two more frames before it reports lock. While locked it keeps checking the time slot 0 words. It drops lock once a programmable number of consecutive checked words are wrong, and three is the default.

After lock is lost, the hunt starts again by itself, or the block waits for software when automatic recovery is switched off. A rising edge on a control input forces a new hunt at any time. The block also outputs the current time slot and bit position, a strobe for one bit of time slot 26, and single-cycle pulses when lock is gained and when it is lost.

Top module: `e1_frame_aligner`

## Requirements
- R1: While reset is asserted, `in_sync`, `slot_num`, `bit_num`, `chblk`, `sync_lost` and `sync_gained` are all 0. Reset is released internally on the second rising clock edge after `rst_n` goes high, so the first bit sampled is the one at the third edge.
- R2: `bit_num` 0..7 gives frame bits 1..8 of a slot, and `slot_num` 0..31 gives the time slot. The pair advances by one on every clock and wraps from slot 31 bit 7 to slot 0 bit 0. A hunt hit loads the pair so that the next bit is reported as slot 1 bit 0.
- R3: The alignment word is 0011011 on frame bits 2..8 of slot 0, with bit 2 received first. During the hunt, each received bit is checked as the last of a 7-bit window. After a hit, bit 2 of slot 0 in the next frame must be 1, and the frame after that must carry the alignment word again. `in_sync` rises on the cycle after bit 8 of that confirming word. Any failed step resumes the hunt at the next bit.
- R4: With `crit_sel` = 0, lock is lost after the alignment word is wrong on three consecutive alignment frames. The bit 2 of the frames in between is ignored.
- R5: With `crit_sel` = 1, a bad bit 2 in the in-between frames also counts as an error, and three consecutive errors of either kind drop lock.
- R6: A checked slot 0 word that is received correctly clears the consecutive-error count.
- R7: With `auto_off` = 0, the hunt restarts at the bit after the loss, and lock is regained from the following frames.
- R8: With `auto_off` = 1, a loss leaves the block out of lock indefinitely, even when clean frames follow.
- R9: A 0-to-1 transition of `resync_req` drops lock if it is held and restarts the hunt from the next bit. Keeping the input high has no further effect, so it must fall and rise again to request another hunt.
- R10: With `chblk_en` = 1, `chblk` is high exactly during slot 26 bit 0 (frame bit 1). With `chblk_en` = 0, `chblk` stays low.
- R11: `sync_gained` pulses for one cycle together with the rise of `in_sync`, and `sync_lost` pulses for one cycle together with its fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 1 | Received serial bit |
| crit_sel | input | 1 | Loss criteria: 0 alignment word only, 1 also bit 2 of in-between word |
| auto_off | input | 1 | 1 disables automatic re-hunt after loss |
| resync_req | input | 1 | Rising edge forces a new hunt |
| chblk_en | input | 1 | Enables the slot 26 strobe |
| in_sync | output | 1 | Frame lock held |
| slot_num | output | 5 | Current time slot |
| bit_num | output | 3 | Current bit within the slot (0 = bit 1) |
| chblk | output | 1 | Slot 26 bit 1 strobe |
| sync_lost | output | 1 | One-cycle pulse on loss of lock |
| sync_gained | output | 1 | One-cycle pulse on gain of lock |

## Verification
The hardest condition to reach is the parked state after a loss with automatic recovery disabled. Getting there takes a lock first, then three bad alignment frames spaced two frames apart, with correct frames ahead of them that clear the count. The stimulus generates whole frames with a per-frame choice of which slot 0 word to corrupt, so lock, clearing, loss and parking follow a fixed frame script. A manual edge then leads out of the parked state, and a held-high request shows that only the edge matters. A final phase with random payload, random corruption and random control changes is compared bit by bit against a behavioural model.

// File: rtl/e1fa_pkg.sv
`timescale 1ns/1ps
package e1fa_pkg;

  typedef enum logic [2:0] {
    ST_HUNT      = 3'd0,
    ST_CONF_NFAS = 3'd1,
    ST_CONF_FAS  = 3'd2,
    ST_LOCKED    = 3'd3,
    ST_PARKED    = 3'd4
  } align_st_t;

  // alignment word on frame bits 2..8 of slot 0, MSB received first
  localparam logic [6:0] ALIGN_WORD = 7'b0011011;

endpackage

// File: rtl/e1fa_rst_sync.sv
`timescale 1ns/1ps
module e1fa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_sync = stage_q[STAGES-1];

endmodule

// File: rtl/e1fa_bit_counter.sv
`timescale 1ns/1ps
module e1fa_bit_counter #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  output logic [SLOT_W-1:0] slot,
  output logic [BIT_W-1:0]  bitn,
  output logic              at_check
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LOAD = SLOT_W'(1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              wrap_bit;

  always_comb begin
    wrap_bit = (bit_q == BIT_LAST);
    slot_d   = slot_q;
    bit_d    = bit_q;
    if (load) begin
      slot_d = SLOT_LOAD;
      bit_d  = '0;
    end else if (wrap_bit) begin
      bit_d  = '0;
      slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      bit_d  = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else begin
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

  assign slot     = slot_q;
  assign bitn     = bit_q;
  assign at_check = (slot_q == '0) && wrap_bit;

endmodule

// File: rtl/e1fa_word_window.sv
`timescale 1ns/1ps
module e1fa_word_window #(
  parameter int                 WORD_W = 7,
  parameter logic [WORD_W-1:0]  PATTERN = e1fa_pkg::ALIGN_WORD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_data,
  output logic word_hit,
  output logic lead_bit
);

  logic [WORD_W-2:0] hist_q, hist_d;
  logic [WORD_W-1:0] window;

  always_comb begin
    window = {hist_q, rx_data};
    hist_d = window[WORD_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign word_hit = (window == PATTERN);
  assign lead_bit = window[WORD_W-1];

endmodule

// File: rtl/e1fa_align_fsm.sv
`timescale 1ns/1ps
module e1fa_align_fsm
  import e1fa_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  localparam int ERR_W    = (ERR_LIMIT > 2) ? $clog2(ERR_LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic word_hit,
  input  logic lead_bit,
  input  logic at_check,
  input  logic crit_sel,
  input  logic auto_off,
  input  logic resync_req,
  output logic load,
  output logic in_sync,
  output logic sync_lost,
  output logic sync_gained
);

  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(ERR_LIMIT - 1);

  align_st_t        st_q, st_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             expf_q, expf_d;
  logic             req_q;
  logic             lost_q, lost_d;
  logic             gain_q, gain_d;
  logic             req_edge;
  logic             word_bad;
  logic             word_checked;

  always_comb begin
    req_edge     = resync_req & ~req_q;
    word_bad     = expf_q ? ~word_hit : (crit_sel & ~lead_bit);
    word_checked = expf_q | crit_sel;
    st_d         = st_q;
    err_d        = err_q;
    expf_d       = expf_q;
    load         = 1'b0;
    if (req_edge) begin
      st_d  = ST_HUNT;
      err_d = '0;
    end else begin
      unique case (st_q)
        ST_HUNT: begin
          if (word_hit) begin
            st_d   = ST_CONF_NFAS;
            expf_d = 1'b0;
            load   = 1'b1;
          end
        end
        ST_CONF_NFAS: begin
          if (at_check) begin
            expf_d = ~expf_q;
            st_d   = lead_bit ? ST_CONF_FAS : ST_HUNT;
          end
        end
        ST_CONF_FAS: begin
          if (at_check) begin
            expf_d = ~expf_q;
            st_d   = word_hit ? ST_LOCKED : ST_HUNT;
          end
        end
        ST_LOCKED: begin
          if (at_check) begin
            expf_d = ~expf_q;
            if (word_bad) begin
              if (err_q == ERR_LAST) begin
                st_d  = auto_off ? ST_PARKED : ST_HUNT;
                err_d = '0;
              end else begin
                err_d = err_q + 1'b1;
              end
            end else if (word_checked) begin
              err_d = '0;
            end
          end
        end
        ST_PARKED: begin
          st_d = ST_PARKED;
        end
        default: begin
          st_d = ST_HUNT;
        end
      endcase
    end
    lost_d = (st_q == ST_LOCKED) && (st_d != ST_LOCKED);
    gain_d = (st_q != ST_LOCKED) && (st_d == ST_LOCKED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      err_q  <= '0;
      expf_q <= 1'b0;
      req_q  <= 1'b0;
      lost_q <= 1'b0;
      gain_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      expf_q <= expf_d;
      req_q  <= resync_req;
      lost_q <= lost_d;
      gain_q <= gain_d;
    end
  end

  assign in_sync     = (st_q == ST_LOCKED);
  assign sync_lost   = lost_q;
  assign sync_gained = gain_q;

endmodule

// File: rtl/e1_frame_aligner.sv
`timescale 1ns/1ps
module e1_frame_aligner #(
  parameter int SLOTS      = 32,
  parameter int SLOT_BITS  = 8,
  parameter int ERR_LIMIT  = 3,
  parameter int CHBLK_SLOT = 26,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int BIT_W     = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_data,
  input  logic              crit_sel,
  input  logic              auto_off,
  input  logic              resync_req,
  input  logic              chblk_en,
  output logic              in_sync,
  output logic [SLOT_W-1:0] slot_num,
  output logic [BIT_W-1:0]  bit_num,
  output logic              chblk,
  output logic              sync_lost,
  output logic              sync_gained
);

  localparam int                WORD_W   = SLOT_BITS - 1;
  localparam logic [SLOT_W-1:0] STRB_SLT = SLOT_W'(CHBLK_SLOT);

  logic rst_n_int;
  logic load;
  logic at_check;
  logic word_hit;
  logic lead_bit;

  e1fa_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  e1fa_word_window #(.WORD_W(WORD_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rx_data  (rx_data),
    .word_hit (word_hit),
    .lead_bit (lead_bit)
  );

  e1fa_bit_counter #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (load),
    .slot     (slot_num),
    .bitn     (bit_num),
    .at_check (at_check)
  );

  e1fa_align_fsm #(.ERR_LIMIT(ERR_LIMIT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .word_hit    (word_hit),
    .lead_bit    (lead_bit),
    .at_check    (at_check),
    .crit_sel    (crit_sel),
    .auto_off    (auto_off),
    .resync_req  (resync_req),
    .load        (load),
    .in_sync     (in_sync),
    .sync_lost   (sync_lost),
    .sync_gained (sync_gained)
  );

  assign chblk = chblk_en && (slot_num == STRB_SLT) && (bit_num == '0);

endmodule

// File: rtl/e1fa_checker.sv
`timescale 1ns/1ps
module e1fa_checker #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int POS_W    = SLOT_W + BIT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              resync_req,
  input logic              in_sync,
  input logic [SLOT_W-1:0] slot_num,
  input logic [BIT_W-1:0]  bit_num,
  input logic              chblk,
  input logic              sync_lost,
  input logic              sync_gained
);

  logic [POS_W-1:0] pos;
  assign pos = {slot_num, bit_num};

  a_r11_lost_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> (!in_sync && $past(in_sync)));

  a_r11_gain_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_gained |-> (in_sync && !$past(in_sync)));

  a_r11_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_lost && sync_gained));

  a_r2_locked_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && $past(in_sync)) |-> (pos == POS_W'($past(pos) + 1'b1)));

  a_r3_lock_position: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> (slot_num == SLOT_W'(1) && bit_num == '0));

  a_r9_manual_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resync_req) |=> !in_sync);

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    chblk |=> !chblk);

endmodule

bind e1_frame_aligner e1fa_checker #(
  .SLOTS     (SLOTS),
  .SLOT_BITS (SLOT_BITS)
) u_e1fa_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .resync_req  (resync_req),
  .in_sync     (in_sync),
  .slot_num    (slot_num),
  .bit_num     (bit_num),
  .chblk       (chblk),
  .sync_lost   (sync_lost),
  .sync_gained (sync_gained)
);

// File: tb/e1_frame_aligner_bench.sv
`timescale 1ns/1ps
module e1_frame_aligner_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_data;
  logic       crit_sel;
  logic       auto_off;
  logic       resync_req;
  logic       chblk_en;
  logic       in_sync;
  logic [4:0] slot_num;
  logic [2:0] bit_num;
  logic       chblk;
  logic       sync_lost;
  logic       sync_gained;

  always #4 clk = ~clk;

  e1_frame_aligner u_e1_frame_aligner (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data     (rx_data),
    .crit_sel    (crit_sel),
    .auto_off    (auto_off),
    .resync_req  (resync_req),
    .chblk_en    (chblk_en),
    .in_sync     (in_sync),
    .slot_num    (slot_num),
    .bit_num     (bit_num),
    .chblk       (chblk),
    .sync_lost   (sync_lost),
    .sync_gained (sync_gained)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int n_lost   = 0;
  int n_gain   = 0;
  int n_strobe = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // states: 0 hunt, 1 confirm in-between word, 2 confirm alignment word, 3 locked, 4 parked
  bit m_hist[$];
  int m_pos, m_state, m_err, m_rel;
  bit m_expect_word, m_req_prev, m_lost, m_gain;

  function automatic bit word_in(bit w[$]);
    bit [6:0] pat = 7'b0011011;
    for (int i = 0; i < 7; i++) if (w[i] != pat[6-i]) return 0;
    return 1;
  endfunction

  task automatic model_reset();
    m_hist = {0, 0, 0, 0, 0, 0};
    m_pos = 0; m_state = 0; m_err = 0;
    m_expect_word = 0; m_req_prev = 0; m_lost = 0; m_gain = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
      m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit w[$];
      bit hit, lead, edge_seen, was_locked, at_chk, bad, checked;
      int nxt;
      w = m_hist;
      w.push_back(rx_data);
      hit  = word_in(w);
      lead = w[0];
      edge_seen = resync_req && !m_req_prev;
      m_req_prev = resync_req;
      was_locked = (m_state == 3);
      at_chk = (m_pos == 7);
      nxt = m_state;
      if (edge_seen) begin
        nxt = 0; m_err = 0; m_pos = (m_pos + 1) % 256;
      end else begin
        if (m_state == 0 && hit) begin
          nxt = 1; m_expect_word = 0; m_pos = 8;
        end else begin
          if (m_state inside {1, 2, 3} && at_chk) begin
            if (m_state == 1) nxt = lead ? 2 : 0;
            else if (m_state == 2) nxt = hit ? 3 : 0;
            else begin
              bad = m_expect_word ? !hit : (crit_sel && !lead);
              checked = m_expect_word || crit_sel;
              if (bad) begin
                m_err++;
                if (m_err >= 3) begin
                  nxt = auto_off ? 4 : 0;
                  m_err = 0;
                end
              end else if (checked) m_err = 0;
            end
            m_expect_word = !m_expect_word;
          end
          m_pos = (m_pos + 1) % 256;
        end
      end
      m_state = nxt;
      m_lost = was_locked && (nxt != 3);
      m_gain = !was_locked && (nxt == 3);
      m_hist.pop_front();
      m_hist.push_back(rx_data);
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R2/R3 model in_sync", int'(in_sync), int'(m_state == 3));
      chk("R2 model slot", int'(slot_num), m_pos / 8);
      chk("R2 model bit", int'(bit_num), m_pos % 8);
      chk("R10 model strobe", int'(chblk), int'(chblk_en && m_pos == 208));
      chk("R11 model lost", int'(sync_lost), int'(m_lost));
      chk("R11 model gained", int'(sync_gained), int'(m_gain));
      if (sync_lost) n_lost++;
      if (sync_gained) n_gain++;
      if (chblk) n_strobe++;
    end
  end

  // ---------------- stimulus ----------------
  int gframe = 0;
  bit rnd_payload = 0;

  function automatic bit frame_bit(int fr, int idx, bit bad_word, bit bad_lead);
    logic [7:0] ts0;
    if (idx < 8) begin
      if (fr % 2 == 0) ts0 = bad_word ? 8'b10011010 : 8'b10011011;
      else             ts0 = bad_lead ? 8'b10011111 : 8'b11011111;
      return ts0[7-idx];
    end
    return rnd_payload ? 1'($urandom % 2) : 1'b1;
  endfunction

  task automatic send_bit(input bit b);
    rx_data = b;
    @(negedge clk);
  endtask

  task automatic send_frame(input bit bad_word, input bit bad_lead);
    for (int i = 0; i < 256; i++) send_bit(frame_bit(gframe, i, bad_word, bad_lead));
    gframe++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base_lost, base_gain, base_strobe;
    rst_n = 0; rx_data = 1; crit_sel = 0; auto_off = 0; resync_req = 0; chblk_en = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset in_sync", int'(in_sync), 0);
    chk("R1 reset slot", int'(slot_num), 0);
    chk("R1 reset bit", int'(bit_num), 0);
    chk("R1 reset pulses", int'(sync_lost | sync_gained | chblk), 0);
    rst_n = 1;
    repeat (5) send_bit(1'b1);

    // R3: acquisition over three frames
    send_frame(0, 0); send_frame(0, 0);
    chk("R3 not yet locked", int'(in_sync), 0);
    send_frame(0, 0);
    chk("R3 locked after confirm", int'(in_sync), 1);
    chk("R11 one gain pulse", n_gain, 1);
    chk("R2 frame start slot", int'(slot_num), 0);
    chk("R2 frame start bit", int'(bit_num), 0);

    // R10: strobe enabled then disabled
    chblk_en = 1; base_strobe = n_strobe;
    send_frame(0, 1);
    chk("R10 strobe once per frame", n_strobe - base_strobe, 1);
    chblk_en = 0; base_strobe = n_strobe;
    send_frame(1, 0);                         // frame 4: error 1
    chk("R10 strobe off", n_strobe - base_strobe, 0);

    // R4/R6: criteria 0, in-between words bad throughout
    send_frame(0, 1); send_frame(1, 1);      // 5, 6: error 2
    send_frame(0, 1); send_frame(0, 1);      // 7, 8: cleared
    send_frame(0, 1); send_frame(1, 1);      // 9, 10: 1
    send_frame(0, 1); send_frame(1, 1);      // 11, 12: 2
    chk("R6 clear keeps lock", int'(in_sync), 1);
    chk("R4 in-between ignored", n_lost, 0);
    send_frame(0, 1); send_frame(1, 1);      // 13, 14: 3 -> loss
    chk("R4 loss after three", int'(in_sync), 0);
    chk("R11 one lost pulse", n_lost, 1);

    // R7: automatic re-hunt
    send_frame(0, 0); send_frame(0, 0); send_frame(0, 0); send_frame(0, 0); // 15..18
    chk("R7 auto reacquire", int'(in_sync), 1);

    // R5: criteria 1
    crit_sel = 1;
    send_frame(0, 1); send_frame(0, 0);      // 19 err, 20 clear
    send_frame(0, 1); send_frame(1, 0);      // 21, 22: 2
    chk("R5 two errors hold", int'(in_sync), 1);
    send_frame(0, 1);                         // 23: 3 -> loss
    chk("R5 mixed loss", int'(in_sync), 0);

    // R8: parked after loss
    crit_sel = 0; auto_off = 1;
    send_frame(0, 0); send_frame(0, 0); send_frame(0, 0); // 24..26
    chk("R8 lock before park", int'(in_sync), 1);
    send_frame(0, 0); send_frame(1, 0); send_frame(0, 0);
    send_frame(1, 0); send_frame(0, 0); send_frame(1, 0); // 27..32
    chk("R8 loss", int'(in_sync), 0);
    base_gain = n_gain;
    for (int f = 0; f < 6; f++) send_frame(0, 0);          // 33..38
    chk("R8 stays parked", int'(in_sync), 0);
    chk("R8 no gain", n_gain - base_gain, 0);

    // R9: manual edge, held high, second edge
    resync_req = 1;
    send_frame(0, 0); send_frame(0, 0); send_frame(0, 0); send_frame(0, 0); // 39..42
    chk("R9 edge restarts hunt", int'(in_sync), 1);
    for (int f = 0; f < 4; f++) send_frame(0, 0);          // 43..46
    chk("R9 held high no effect", int'(in_sync), 1);
    resync_req = 0;
    send_frame(0, 0);                                       // 47
    base_lost = n_lost;
    resync_req = 1;
    send_bit(frame_bit(gframe, 0, 0, 0));
    chk("R9 edge drops lock", int'(in_sync), 0);
    chk("R11 lost on manual", n_lost - base_lost, 1);
    for (int i = 1; i < 256; i++) send_bit(frame_bit(gframe, i, 0, 0));
    gframe++;                                               // 48
    resync_req = 0; auto_off = 0;
    send_frame(0, 0); send_frame(0, 0); send_frame(0, 0); send_frame(0, 0); // 49..52
    chk("R7 lock after manual hunt", int'(in_sync), 1);

    // random mixed phase, compared against the model each clock
    rnd_payload = 1;
    for (int f = 0; f < 40; f++) begin
      crit_sel = 1'($urandom % 2);
      chblk_en = 1'($urandom % 2);
      auto_off = ($urandom % 8) == 0;
      resync_req = ($urandom % 10) == 0;
      send_frame(($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    finish_run();
  end

endmodule